// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block steers operands and controls stalls in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose conditional branches are resolved in decode. It is purely combinational. Each cycle it receives the source register numbers of the instructions in decode and execute. It also receives the destination number, register-write flag and load flag of the instructions in execute, memory and writeback.

It produces four kinds of output. Two selects choose the source of each execute-stage ALU operand: register file, memory-stage result or writeback-stage result. Two selects choose the source of each operand of the decode-stage equality comparator. It also produces a stall that holds the PC and the fetch/decode register, a bubble that clears the controls entering execute, and a flush that turns the fetched instruction behind a taken branch into a nop.

Branches compare operands in decode, so they need their values one stage earlier than the ALU does. This adds stall cases on top of the usual load-use case. The register file writes before it reads, so a writeback-stage producer never needs forwarding into decode.

Top module: `hzu_top`

## Requirements
- R1: An execute operand whose register matches the memory-stage destination (write flag set, register nonzero) selects 2'b01 (memory-stage result).
- R2: An execute operand that matches only the writeback-stage destination (write flag set, register nonzero) selects 2'b10 (writeback result). Otherwise the select is 2'b00 (register file).
- R3: When both the memory and writeback stages match an execute operand, the memory stage wins and the select is 2'b01.
- R4: Register 0, or a producer with its write flag clear, never causes forwarding in either stage and never causes a stall.
- R5: A load in execute whose destination matches either decode source raises stall_o and bubble_o together.
- R6: A writeback-stage producer matching a decode source causes neither stall nor decode forwarding; the decode selects stay 0.
- R7: A decode comparator operand that matches a non-load memory-stage writer selects 1 (memory-stage result) without a stall.
- R8: A branch in decode whose source matches any register writer in execute, load or not, stalls.
- R9: A branch in decode whose source matches a load in the memory stage stalls. A load directly ahead of a branch therefore costs two stall cycles, and a load one instruction further ahead costs one.
- R10: flush_o is 1 exactly when a branch is in decode, its comparison is taken and stall_o is 0.
- R11: A non-load writer in execute matching a decode source of a non-branch instruction causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | REG_W | First source register of the decode instruction |
| id_rt_i | input | REG_W | Second source register of the decode instruction |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_taken_i | input | 1 | Decode comparator reports the branch taken |
| ex_rs_i | input | REG_W | First source register of the execute instruction |
| ex_rt_i | input | REG_W | Second source register of the execute instruction |
| ex_rd_i | input | REG_W | Destination register of the execute instruction |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | REG_W | Destination register of the writeback instruction |
| wb_wr_i | input | 1 | Writeback instruction writes a register |
| ex_fwd_a_o | output | 2 | Execute operand A source: 00 file, 01 memory, 10 writeback |
| ex_fwd_b_o | output | 2 | Execute operand B source, same coding |
| id_fwd_a_o | output | 1 | Comparator operand A taken from memory-stage result |
| id_fwd_b_o | output | 1 | Comparator operand B taken from memory-stage result |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Clear controls entering execute |
| flush_o | output | 1 | Squash the instruction fetched behind a taken branch |

## Verification
The assertions assume that the load flag is only set together with the write flag. They also assume that a memory-stage load never matches an execute-stage source, because the load-use stall is meant to prevent that combination. The exhaustive sweep drives a load flag for each stage independently of its write flag, and the forwarding and stall expectations are computed so that they hold for every such mix. The directed pipeline walk drives only the instruction sequences that a correctly stalled pipeline would produce.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MEM = 2'b01,
    SRC_WB  = 2'b10
  } ex_src_e;
endpackage

// File: rtl/hzu_ex_fwd.sv
module hzu_ex_fwd
  import hzu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wr_i,
  output ex_src_e          sel_o
);
  logic src_nz, hit_mem, hit_wb;

  assign src_nz  = |src_i;
  assign hit_mem = src_nz && mem_wr_i && (mem_rd_i == src_i);
  assign hit_wb  = src_nz && wb_wr_i  && (wb_rd_i  == src_i);

  // newer producer first
  always_comb begin
    if (hit_mem)     sel_o = SRC_MEM;
    else if (hit_wb) sel_o = SRC_WB;
    else             sel_o = SRC_RF;
  end
endmodule

// File: rtl/hzu_id_fwd.sv
module hzu_id_fwd #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic             mem_load_i,
  output logic             sel_o
);
  // load data is not ready before end of MEM: stall path handles it
  assign sel_o = (|src_i) && mem_wr_i && !mem_load_i && (mem_rd_i == src_i);
endmodule

// File: rtl/hzu_stall.sv
module hzu_stall #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wr_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic             mem_load_i,
  output logic             stall_o
);
  logic ex_hit, mem_hit, load_use, br_ex, br_mem;

  assign ex_hit  = ex_wr_i && (|ex_rd_i) &&
                   ((ex_rd_i == id_rs_i) || (ex_rd_i == id_rt_i));
  assign mem_hit = mem_wr_i && (|mem_rd_i) &&
                   ((mem_rd_i == id_rs_i) || (mem_rd_i == id_rt_i));

  assign load_use = ex_hit && ex_load_i;
  assign br_ex    = ex_hit && id_branch_i;
  assign br_mem   = mem_hit && mem_load_i && id_branch_i;

  assign stall_o = load_use || br_ex || br_mem;
endmodule

// File: rtl/hzu_top.sv
module hzu_top
  import hzu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic             id_taken_i,
  input  logic [REG_W-1:0] ex_rs_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wr_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic             mem_load_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wr_i,
  output logic [1:0]       ex_fwd_a_o,
  output logic [1:0]       ex_fwd_b_o,
  output logic             id_fwd_a_o,
  output logic             id_fwd_b_o,
  output logic             stall_o,
  output logic             bubble_o,
  output logic             flush_o
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][REG_W-1:0] ex_src, id_src;
  ex_src_e [NOPS-1:0]         ex_sel;
  logic [NOPS-1:0]            id_sel;
  logic                       stall;

  assign ex_src = {ex_rt_i, ex_rs_i};
  assign id_src = {id_rt_i, id_rs_i};

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    hzu_ex_fwd #(.REG_W(REG_W)) u_ex_fwd (
      .src_i   (ex_src[g]),
      .mem_rd_i(mem_rd_i),
      .mem_wr_i(mem_wr_i),
      .wb_rd_i (wb_rd_i),
      .wb_wr_i (wb_wr_i),
      .sel_o   (ex_sel[g])
    );
    hzu_id_fwd #(.REG_W(REG_W)) u_id_fwd (
      .src_i     (id_src[g]),
      .mem_rd_i  (mem_rd_i),
      .mem_wr_i  (mem_wr_i),
      .mem_load_i(mem_load_i),
      .sel_o     (id_sel[g])
    );
  end

  hzu_stall #(.REG_W(REG_W)) u_stall (
    .id_rs_i    (id_rs_i),
    .id_rt_i    (id_rt_i),
    .id_branch_i(id_branch_i),
    .ex_rd_i    (ex_rd_i),
    .ex_wr_i    (ex_wr_i),
    .ex_load_i  (ex_load_i),
    .mem_rd_i   (mem_rd_i),
    .mem_wr_i   (mem_wr_i),
    .mem_load_i (mem_load_i),
    .stall_o    (stall)
  );

  assign ex_fwd_a_o = ex_sel[0];
  assign ex_fwd_b_o = ex_sel[1];
  assign id_fwd_a_o = id_sel[0];
  assign id_fwd_b_o = id_sel[1];
  assign stall_o    = stall;
  assign bubble_o   = stall;
  assign flush_o    = id_branch_i && id_taken_i && !stall;

  always_comb begin
    AST_SEL_LEGAL: assert (ex_sel[0] != 2'b11 && ex_sel[1] != 2'b11); // R1
    AST_ZERO_NO_FWD: assert ((|ex_rs_i) || ex_sel[0] == SRC_RF); // R4
    AST_LOAD_USE: assert (!(ex_load_i && ex_wr_i && (|ex_rd_i) &&
                            ex_rd_i == id_rs_i) || stall); // R5
    AST_BR_EX_STALL: assert (!(id_branch_i && ex_wr_i && (|ex_rd_i) &&
                               ex_rd_i == id_rt_i) || stall); // R8
    AST_FLUSH_NOT_STALL: assert (!(flush_o && stall)); // R10
  end
endmodule

// File: tb/hzu_top_tb.sv
`timescale 1ns/1ps
module hzu_top_tb;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_branch, id_taken, ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic id_fwd_a, id_fwd_b, stall, bubble, flush;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  hzu_top #(.REG_W(REG_W)) u_dut (
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_branch_i(id_branch), .id_taken_i(id_taken),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_rd_i(ex_rd), .ex_wr_i(ex_wr),
    .ex_load_i(ex_load), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .mem_load_i(mem_load), .wb_rd_i(wb_rd), .wb_wr_i(wb_wr),
    .ex_fwd_a_o(ex_fwd_a), .ex_fwd_b_o(ex_fwd_b), .id_fwd_a_o(id_fwd_a),
    .id_fwd_b_o(id_fwd_b), .stall_o(stall), .bubble_o(bubble), .flush_o(flush)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ex(input int src);
    bit m = (src != 0) && mem_wr && (int'(mem_rd) == src);
    bit w = (src != 0) && wb_wr && (int'(wb_rd) == src);
    return m ? 1 : (w ? 2 : 0);
  endfunction

  function automatic string ex_tag(input int src);
    bit m = (src != 0) && mem_wr && (int'(mem_rd) == src);
    bit w = (src != 0) && wb_wr && (int'(wb_rd) == src);
    if (m && w) return "R3";
    if (m) return "R1";
    if (w) return "R2";
    return "R4";
  endfunction

  function automatic int exp_id(input int src);
    return ((src != 0) && mem_wr && !mem_load && (int'(mem_rd) == src)) ? 1 : 0;
  endfunction

  task automatic idle();
    id_rs = '0; id_rt = '0; ex_rs = '0; ex_rt = '0; ex_rd = '0;
    mem_rd = '0; wb_rd = '0; id_branch = 0; id_taken = 0;
    ex_wr = 0; ex_load = 0; mem_wr = 0; mem_load = 0; wb_wr = 0;
  endtask

  task automatic check_all();
    bit exh, memh, es;
    string st;
    #1;
    chk(ex_tag(int'(ex_rs)), int'(ex_fwd_a), exp_ex(int'(ex_rs)));
    chk(ex_tag(int'(ex_rt)), int'(ex_fwd_b), exp_ex(int'(ex_rt)));
    chk(exp_id(int'(id_rs)) != 0 ? "R7" : "R6", int'(id_fwd_a), exp_id(int'(id_rs)));
    chk(exp_id(int'(id_rt)) != 0 ? "R7" : "R6", int'(id_fwd_b), exp_id(int'(id_rt)));
    exh  = ex_wr && ex_rd != 0 && (ex_rd == id_rs || ex_rd == id_rt);
    memh = mem_wr && mem_rd != 0 && (mem_rd == id_rs || mem_rd == id_rt);
    es = (exh && (ex_load || id_branch)) || (memh && mem_load && id_branch);
    if (es) st = !id_branch ? "R5" : (exh ? "R8" : "R9");
    else st = id_branch ? "R6" : "R11";
    chk(st, int'(stall), int'(es));
    chk("R5", int'(bubble), int'(es));
    chk("R10", int'(flush), int'(id_branch && id_taken && !es));
    #1;
  endtask

  initial begin
    idle();
    #1;
    // reset state: quiet pipeline
    chk("R4", int'(ex_fwd_a), 0); chk("R4", int'(ex_fwd_b), 0);
    chk("R6", int'(id_fwd_a), 0); chk("R6", int'(stall), 0);
    chk("R10", int'(flush), 0);

    // directed: load directly ahead of branch -> two stalls (R9)
    idle(); id_branch = 1; id_taken = 1; id_rs = 5'd7; id_rt = 5'd3;
    ex_rd = 5'd7; ex_wr = 1; ex_load = 1; #1;
    chk("R8", int'(stall), 1); chk("R10", int'(flush), 0);
    ex_wr = 0; ex_load = 0; ex_rd = 0;
    mem_rd = 5'd7; mem_wr = 1; mem_load = 1; #1;
    chk("R9", int'(stall), 1); chk("R7", int'(id_fwd_a), 0);
    mem_wr = 0; mem_load = 0; mem_rd = 0; wb_rd = 5'd7; wb_wr = 1; #1;
    chk("R6", int'(stall), 0); chk("R10", int'(flush), 1);
    // ALU ahead of non-branch: forward, no stall (R11)
    idle(); id_rs = 5'd4; ex_rd = 5'd4; ex_wr = 1; #1;
    chk("R11", int'(stall), 0);

    // exhaustive sweep over registers 0..3
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int e = 0; e < 4; e++)
          for (int m = 0; m < 4; m++)
            for (int w = 0; w < 4; w++)
              for (int f = 0; f < 32; f++)
                for (int br = 0; br < 2; br++) begin
                  id_rs = REG_W'(a); id_rt = REG_W'(b);
                  ex_rs = REG_W'(a); ex_rt = REG_W'(b);
                  ex_rd = REG_W'(e); mem_rd = REG_W'(m); wb_rd = REG_W'(w);
                  ex_wr = f[0]; ex_load = f[1]; mem_wr = f[2];
                  mem_load = f[3]; wb_wr = f[4];
                  id_branch = br[0]; id_taken = f[0] ^ a[0];
                  check_all();
                end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule